// File: doc/BRIEF.md
# Peripheral Port Decoder and Control Latch

This block sits on an 8-bit host I/O bus and serves three ports: a line port for a shared serial/network wire, a control/status port, and a data port for a tape-cartridge drive. Address bits 4 and 3 choose the port and all other address bits are ignored. When both bits are 1, the block does not claim the access and passes it to a downstream bus device.

Every signal on the ports is active low. The control port holds a latch that drives the drive mechanism, the serial clear-to-send line and the network wait request. On a write, the new byte is compared with the old one by XOR, and only the groups that changed raise their strobe toward the subsystems. Reading the control port returns a status byte built from the drive condition flags, the serial DTR level and the network busy flag. Latch bit 0 decides whether a write to the line port goes to the serial receive input or onto the network wire.

All strobes are single-cycle pulses that appear in the cycle after the write. Read data is registered and is valid one cycle after the read strobe.

Top module: `ioport_hub`

## Requirements
- R1: Only address bits 4:3 select the port: 2'b10 selects the line port, 2'b01 the control port and 2'b00 the data port. `bus_hit` is high in the cycle of a read or write to any of these ports, whatever the other address bits are.
- R2: Address bits 4:3 = 2'b11 are forwarded. `bus_hit` stays low, `fwd_rd` and `fwd_wr` follow `bus_rd` and `bus_wr` in the same cycle, the read returns `fwd_rdata`, and the control latch is not changed.
- R3: A control port read returns {3'b111, ~net_busy, ~ser_dtr, ~drv_gap, ~drv_sync, ~drv_wprot}. With all drive flags low and DTR and busy both high, this is 0xE7.
- R4: A control port write stores the written byte in the control latch. Reset loads the latch with 0xEE.
- R5: If bits 3:0 of a control write differ from the latched bits, `drv_ctl_stb` pulses once. It carries `drv_erase` = ~bit3, `drv_write` = ~bit2, `drv_clk` = ~bit1 and `drv_dout` = ~bit0. If none of bits 3:0 change, there is no pulse.
- R6: If latch bit 4 changes on a control write, `ser_cts_stb` pulses and carries `ser_cts` = ~bit4 (high means CTS asserted). If bit 4 does not change, there is no pulse.
- R7: Every control write with bit 5 = 0 pulses `net_wait_stb`, even when bit 5 did not change. A write with bit 5 = 1 gives no pulse.
- R8: A line port write is steered by latch bit 0. When the bit is 1, `ser_rxd_stb` pulses with `ser_rxd` = ~wdata[0]. When the bit is 0, `net_send_stb` pulses with `net_send` = ~wdata[0]. Only one of the two strobes pulses.
- R9: A line port read returns a held byte with bits 6:1 = 1. On each read, bit 7 is updated to ~ser_txd. Bit 0 is updated to `net_line` only while latch bit 4 is 1 (CTS inactive) and otherwise keeps its value. The reset value is 0x7E.
- R10: A data port write gives a one-cycle `drv_wr_stb` with `drv_wdata` equal to the written byte. A data port read raises `drv_rd_stb` in the read cycle and returns `drv_rdata`.
- R11: `bus_rdata` updates at the clock edge that ends the read cycle and holds its value otherwise. Each write strobe is high for exactly the one cycle after the write.
- R12: Reset is synchronous. It clears all strobes and `bus_rdata` and restores the latch (0xEE) and the line byte (0x7E).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 16 | I/O address |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Registered read data |
| bus_hit | output | 1 | Access claimed by this block |
| fwd_rd | output | 1 | Forwarded read |
| fwd_wr | output | 1 | Forwarded write |
| fwd_rdata | input | 8 | Read data from the downstream device |
| drv_wprot | input | 1 | Cartridge write-protected |
| drv_sync | input | 1 | Sync detected |
| drv_gap | input | 1 | Gap detected |
| drv_rdata | input | 8 | Drive data channel, read side |
| drv_rd_stb | output | 1 | Drive data read strobe |
| drv_wr_stb | output | 1 | Drive data write strobe |
| drv_wdata | output | 8 | Drive data channel, write side |
| drv_ctl_stb | output | 1 | Drive control update strobe |
| drv_erase | output | 1 | Erase request level |
| drv_write | output | 1 | Write-mode level |
| drv_clk | output | 1 | Comms clock level |
| drv_dout | output | 1 | Comms data-out level |
| ser_dtr | input | 1 | Serial DTR level |
| ser_txd | input | 1 | Serial transmit data level |
| ser_rxd_stb | output | 1 | Serial receive-bit strobe |
| ser_rxd | output | 1 | Serial receive-bit level |
| ser_cts_stb | output | 1 | CTS update strobe |
| ser_cts | output | 1 | CTS level |
| net_line | input | 1 | Network line state |
| net_busy | input | 1 | Network busy flag |
| net_send_stb | output | 1 | Network send strobe |
| net_send | output | 1 | Network line level to send |
| net_wait_stb | output | 1 | Network wait request strobe |

## Verification
Control writes are chosen so that only one bit group changes at a time: first bit 4 alone, then bit 0 alone, then all of bits 3:0, then only bit 5, and finally a repeat of the same byte. This shows that each strobe is gated by its own XOR group and not by the write as a whole, and the repeated byte shows that the wait strobe depends on the level of bit 5, not on a change. Line reads are done with the CTS bit both set and cleared while `net_line` moves, which tells a refreshed bit 0 apart from a held one. Line writes are done under both routing settings. Addresses with noisy upper bits, and the 2'b11 pattern, show that only bits 4:3 are decoded.

// File: rtl/ioport_pkg.sv
package ioport_pkg;

    typedef enum logic [1:0] {
        PORT_DATA = 2'b00,
        PORT_CTRL = 2'b01,
        PORT_LINE = 2'b10,
        PORT_FWD  = 2'b11
    } port_e;

    localparam int unsigned BYTE_W      = 8;
    localparam logic [7:0]  CTRL_RESET  = 8'hEE;
    localparam logic [7:0]  LINE_RESET  = 8'h7E;

    // control latch bit positions
    localparam int unsigned CB_DOUT  = 0;
    localparam int unsigned CB_CLK   = 1;
    localparam int unsigned CB_WRITE = 2;
    localparam int unsigned CB_ERASE = 3;
    localparam int unsigned CB_CTS   = 4;
    localparam int unsigned CB_WAIT  = 5;

endpackage

// File: rtl/ioport_decode.sv
module ioport_decode #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned SEL_LO = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output logic              sel_data,
    output logic              sel_ctrl,
    output logic              sel_line,
    output logic              sel_fwd
);
    import ioport_pkg::*;

    localparam int unsigned SEL_HI = SEL_LO + 1;

    port_e port;
    logic  access;

    always_comb begin
        port     = port_e'(addr[SEL_HI:SEL_LO]);
        access   = rd | wr;
        sel_data = access && (port == PORT_DATA);
        sel_ctrl = access && (port == PORT_CTRL);
        sel_line = access && (port == PORT_LINE);
        sel_fwd  = access && (port == PORT_FWD);
    end

    assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel_data, sel_ctrl, sel_line, sel_fwd}));

    assert_sel_covers_R2: assert property (@(posedge clk) disable iff (rst)
        (rd | wr) |-> $countones({sel_data, sel_ctrl, sel_line, sel_fwd}) == 1);

endmodule

// File: rtl/ioport_ctrl.sv
module ioport_ctrl #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_ctrl,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] latch,
    output logic          ctl_stb,
    output logic          erase,
    output logic          write_mode,
    output logic          comms_clk,
    output logic          comms_dout,
    output logic          cts_stb,
    output logic          cts,
    output logic          wait_stb
);
    import ioport_pkg::*;

    localparam int unsigned DRV_BITS = CB_ERASE + 1;

    typedef struct packed {
        logic [DW-1:0] latch;
        logic          ctl_stb;
        logic          erase;
        logic          write_mode;
        logic          comms_clk;
        logic          comms_dout;
        logic          cts_stb;
        logic          cts;
        logic          wait_stb;
    } ctrl_st_t;

    ctrl_st_t      st_d, st_q;
    logic [DW-1:0] diff;

    always_comb begin
        st_d          = st_q;
        st_d.ctl_stb  = 1'b0;
        st_d.cts_stb  = 1'b0;
        st_d.wait_stb = 1'b0;
        diff          = st_q.latch ^ wdata;
        if (wr_ctrl) begin
            st_d.latch = wdata;
            if (|diff[DRV_BITS-1:0]) begin
                st_d.ctl_stb    = 1'b1;
                st_d.erase      = ~wdata[CB_ERASE];
                st_d.write_mode = ~wdata[CB_WRITE];
                st_d.comms_clk  = ~wdata[CB_CLK];
                st_d.comms_dout = ~wdata[CB_DOUT];
            end
            if (diff[CB_CTS]) begin
                st_d.cts_stb = 1'b1;
                st_d.cts     = ~wdata[CB_CTS];
            end
            if (!wdata[CB_WAIT]) begin
                st_d.wait_stb = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q            <= '0;
            st_q.latch      <= CTRL_RESET;
            st_q.erase      <= ~CTRL_RESET[CB_ERASE];
            st_q.write_mode <= ~CTRL_RESET[CB_WRITE];
            st_q.comms_clk  <= ~CTRL_RESET[CB_CLK];
            st_q.comms_dout <= ~CTRL_RESET[CB_DOUT];
            st_q.cts        <= ~CTRL_RESET[CB_CTS];
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        latch      = st_q.latch;
        ctl_stb    = st_q.ctl_stb;
        erase      = st_q.erase;
        write_mode = st_q.write_mode;
        comms_clk  = st_q.comms_clk;
        comms_dout = st_q.comms_dout;
        cts_stb    = st_q.cts_stb;
        cts        = st_q.cts;
        wait_stb   = st_q.wait_stb;
    end

    assert_latch_store_R4: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> latch == $past(wdata));

    assert_latch_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !wr_ctrl |=> $stable(latch));

    assert_drv_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && (latch[3:0] != wdata[3:0])) |=> ctl_stb && (comms_dout == !$past(wdata[0])));

    assert_drv_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && (latch[3:0] == wdata[3:0])) |=> !ctl_stb);

    assert_cts_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && (latch[4] != wdata[4])) |=> cts_stb && (cts == latch[4] ^ 1'b1));

    assert_wait_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !wdata[5]) |=> wait_stb);

    assert_strobe_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        !wr_ctrl |=> !(ctl_stb | cts_stb | wait_stb));

endmodule

// File: rtl/ioport_line.sv
module ioport_line #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_line,
    input  logic          wr_line,
    input  logic [DW-1:0] wdata,
    input  logic          route_serial,
    input  logic          cts_inactive,
    input  logic          ser_txd,
    input  logic          net_line,
    output logic [DW-1:0] rd_byte,
    output logic          rxd_stb,
    output logic          rxd,
    output logic          send_stb,
    output logic          send
);
    import ioport_pkg::*;

    typedef struct packed {
        logic [DW-1:0] line;
        logic          rxd_stb;
        logic          rxd;
        logic          send_stb;
        logic          send;
    } line_st_t;

    line_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.rxd_stb  = 1'b0;
        st_d.send_stb = 1'b0;
        if (rd_line) begin
            st_d.line[DW-1] = ~ser_txd;
            if (cts_inactive) begin
                st_d.line[0] = net_line;
            end
        end
        if (wr_line) begin
            if (route_serial) begin
                st_d.rxd_stb = 1'b1;
                st_d.rxd     = ~wdata[0];
            end else begin
                st_d.send_stb = 1'b1;
                st_d.send     = ~wdata[0];
            end
        end
        rd_byte = st_d.line;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            st_q.line <= LINE_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rxd_stb  = st_q.rxd_stb;
        rxd      = st_q.rxd;
        send_stb = st_q.send_stb;
        send     = st_q.send;
    end

    assert_route_excl_R8: assert property (@(posedge clk) disable iff (rst)
        wr_line |=> (rxd_stb ^ send_stb));

    assert_route_pick_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_line && route_serial) |=> rxd_stb && (rxd == !$past(wdata[0])));

    assert_bit0_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_line && !cts_inactive) |=> st_q.line[0] == $past(st_q.line[0]));

    assert_fixed_bits_R9: assert property (@(posedge clk) disable iff (rst)
        st_q.line[DW-2:1] == LINE_RESET[DW-2:1]);

endmodule

// File: rtl/ioport_hub.sv
module ioport_hub #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned SEL_LO = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [7:0]        bus_rdata,
    output logic              bus_hit,
    output logic              fwd_rd,
    output logic              fwd_wr,
    input  logic [7:0]        fwd_rdata,
    input  logic              drv_wprot,
    input  logic              drv_sync,
    input  logic              drv_gap,
    input  logic [7:0]        drv_rdata,
    output logic              drv_rd_stb,
    output logic              drv_wr_stb,
    output logic [7:0]        drv_wdata,
    output logic              drv_ctl_stb,
    output logic              drv_erase,
    output logic              drv_write,
    output logic              drv_clk,
    output logic              drv_dout,
    input  logic              ser_dtr,
    input  logic              ser_txd,
    output logic              ser_rxd_stb,
    output logic              ser_rxd,
    output logic              ser_cts_stb,
    output logic              ser_cts,
    input  logic              net_line,
    input  logic              net_busy,
    output logic              net_send_stb,
    output logic              net_send,
    output logic              net_wait_stb
);
    import ioport_pkg::*;

    localparam int unsigned DW = BYTE_W;

    logic          sel_data, sel_ctrl, sel_line, sel_fwd;
    logic [DW-1:0] latch;
    logic [DW-1:0] line_byte;
    logic [DW-1:0] status_byte;

    typedef struct packed {
        logic [DW-1:0] rdata;
        logic          wr_stb;
        logic [DW-1:0] wdata;
    } hub_st_t;

    hub_st_t st_d, st_q;

    ioport_decode #(.ADDR_W(ADDR_W), .SEL_LO(SEL_LO)) u_dec (
        .clk      (clk),
        .rst      (rst),
        .addr     (bus_addr),
        .rd       (bus_rd),
        .wr       (bus_wr),
        .sel_data (sel_data),
        .sel_ctrl (sel_ctrl),
        .sel_line (sel_line),
        .sel_fwd  (sel_fwd)
    );

    ioport_ctrl #(.DW(DW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_ctrl    (sel_ctrl & bus_wr),
        .wdata      (bus_wdata),
        .latch      (latch),
        .ctl_stb    (drv_ctl_stb),
        .erase      (drv_erase),
        .write_mode (drv_write),
        .comms_clk  (drv_clk),
        .comms_dout (drv_dout),
        .cts_stb    (ser_cts_stb),
        .cts        (ser_cts),
        .wait_stb   (net_wait_stb)
    );

    ioport_line #(.DW(DW)) u_line (
        .clk          (clk),
        .rst          (rst),
        .rd_line      (sel_line & bus_rd),
        .wr_line      (sel_line & bus_wr),
        .wdata        (bus_wdata),
        .route_serial (latch[CB_DOUT]),
        .cts_inactive (latch[CB_CTS]),
        .ser_txd      (ser_txd),
        .net_line     (net_line),
        .rd_byte      (line_byte),
        .rxd_stb      (ser_rxd_stb),
        .rxd          (ser_rxd),
        .send_stb     (net_send_stb),
        .send         (net_send)
    );

    always_comb begin
        status_byte = {3'b111, ~net_busy, ~ser_dtr, ~drv_gap, ~drv_sync, ~drv_wprot};
        st_d        = st_q;
        st_d.wr_stb = 1'b0;
        if (bus_rd) begin
            if (sel_line)      st_d.rdata = line_byte;
            else if (sel_ctrl) st_d.rdata = status_byte;
            else if (sel_data) st_d.rdata = drv_rdata;
            else               st_d.rdata = fwd_rdata;
        end
        if (bus_wr && sel_data) begin
            st_d.wr_stb = 1'b1;
            st_d.wdata  = bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_hit    = sel_data | sel_ctrl | sel_line;
        fwd_rd     = sel_fwd & bus_rd;
        fwd_wr     = sel_fwd & bus_wr;
        drv_rd_stb = sel_data & bus_rd;
        bus_rdata  = st_q.rdata;
        drv_wr_stb = st_q.wr_stb;
        drv_wdata  = st_q.wdata;
    end

    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    assert_data_write_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel_data) |=> drv_wr_stb && (drv_wdata == $past(bus_wdata)));

    assert_fwd_read_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && sel_fwd) |=> bus_rdata == $past(fwd_rdata));

    assert_status_read_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && sel_ctrl) |=> bus_rdata[2:0] == ~$past({drv_gap, drv_sync, drv_wprot}));

endmodule

// File: tb/sim_ioport_hub.sv
module sim_ioport_hub;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_rdata;
    logic        bus_hit, fwd_rd, fwd_wr;
    logic [7:0]  fwd_rdata = '0;
    logic        drv_wprot = 0, drv_sync = 0, drv_gap = 0;
    logic [7:0]  drv_rdata = '0;
    logic        drv_rd_stb, drv_wr_stb;
    logic [7:0]  drv_wdata;
    logic        drv_ctl_stb, drv_erase, drv_write, drv_clk, drv_dout;
    logic        ser_dtr = 1, ser_txd = 1;
    logic        ser_rxd_stb, ser_rxd, ser_cts_stb, ser_cts;
    logic        net_line = 0, net_busy = 1;
    logic        net_send_stb, net_send, net_wait_stb;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ioport_hub u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        bus_rd = 0; bus_wr = 0;
    endtask

    // drive a write; after return we are at the negedge where strobes are visible
    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1;
        @(negedge clk);
        bus_rd = 0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        chk("R12 rdata", bus_rdata, 0);
        chk("R12 strobes", {drv_ctl_stb, ser_cts_stb, net_wait_stb, drv_wr_stb, ser_rxd_stb, net_send_stb}, 0);
    endtask

    task automatic t_status();
        logic [7:0] d;
        rd(16'h0008, d);
        chk("R3 idle status", d, 8'hE7);
        drv_wprot = 1; drv_gap = 1; ser_dtr = 0; net_busy = 0;
        rd(16'hF70F, d);
        chk("R3 flags status", d, 8'hFA);
        drv_wprot = 0; drv_gap = 0; ser_dtr = 1; net_busy = 1;
        idle();
        chk("R11 rdata held", bus_rdata, 8'hFA);
    endtask

    task automatic t_line_cts();
        logic [7:0] d;
        net_line = 1; ser_txd = 1;
        rd(16'h0010, d);
        chk("R9 held bit0 cts active", d, 8'h7E);
        wr(16'h0008, 8'hFE);
        chk("R6 cts strobe", {ser_cts_stb, ser_cts}, 2'b10);
        chk("R5 no drv strobe", drv_ctl_stb, 0);
        chk("R7 no wait", net_wait_stb, 0);
        idle();
        chk("R11 cts pulse ends", ser_cts_stb, 0);
        ser_txd = 0;
        rd(16'h0010, d);
        chk("R9 refresh bit0", d, 8'hFF);
        wr(16'h0008, 8'hEE);
        chk("R6 cts back", {ser_cts_stb, ser_cts}, 2'b11);
        net_line = 0; ser_txd = 1;
        rd(16'hAB10, d);
        chk("R9 bit0 kept, bit7 follows", d, 8'h7F);
    endtask

    task automatic t_route();
        wr(16'h0010, 8'h00);
        chk("R8 net route", {net_send_stb, net_send, ser_rxd_stb}, 3'b110);
        wr(16'h0008, 8'hEF);
        chk("R5 dout change", {drv_ctl_stb, drv_erase, drv_write, drv_clk, drv_dout}, 5'b10000);
        wr(16'h0010, 8'h01);
        chk("R8 serial route", {ser_rxd_stb, ser_rxd, net_send_stb}, 3'b100);
        idle();
        chk("R11 route pulse ends", {ser_rxd_stb, net_send_stb}, 0);
    endtask

    task automatic t_ctrl();
        wr(16'h0008, 8'hE0);
        chk("R5 all drive bits", {drv_ctl_stb, drv_erase, drv_write, drv_clk, drv_dout}, 5'b11111);
        chk("R7 bit5 high no wait", net_wait_stb, 0);
        wr(16'h0008, 8'hC0);
        chk("R7 wait on bit5 low", net_wait_stb, 1);
        chk("R5 unchanged no strobe", {drv_ctl_stb, ser_cts_stb}, 0);
        wr(16'h0008, 8'hC0);
        chk("R7 wait repeated", net_wait_stb, 1);
        idle();
        chk("R11 wait pulse ends", net_wait_stb, 0);
    endtask

    task automatic t_data_fwd();
        logic [7:0] d;
        wr(16'hFF00, 8'hA5);
        chk("R10 data write", {drv_wr_stb, drv_wdata}, {1'b1, 8'hA5});
        drv_rdata = 8'h3C;
        @(negedge clk);
        bus_addr = 16'h00E7; bus_rd = 1;
        #2;
        chk("R10 rd strobe", drv_rd_stb, 1);
        chk("R1 hit data", bus_hit, 1);
        @(negedge clk);
        bus_rd = 0;
        chk("R10 data read", bus_rdata, 8'h3C);
        fwd_rdata = 8'h99;
        @(negedge clk);
        bus_addr = 16'h0018; bus_rd = 1;
        #2;
        chk("R2 fwd read", {bus_hit, fwd_rd, drv_rd_stb}, 3'b010);
        @(negedge clk);
        bus_rd = 0;
        chk("R2 fwd rdata", bus_rdata, 8'h99);
        @(negedge clk);
        bus_addr = 16'h5A1F; bus_wdata = 8'h3F; bus_wr = 1;
        #2;
        chk("R2 fwd write", {bus_hit, fwd_wr}, 2'b01);
        @(negedge clk);
        bus_wr = 0;
        chk("R2 latch untouched", {drv_ctl_stb, ser_cts_stb, net_wait_stb}, 0);
        // latch still 0xC0 (bit0=0): a line write still goes to network
        wr(16'h0010, 8'h00);
        chk("R2 route unchanged", {net_send_stb, ser_rxd_stb}, 2'b10);
        wr(16'h0008, 8'hC0);
        chk("R4 latch still C0", {drv_ctl_stb, ser_cts_stb}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_status();
        t_line_cts();
        t_route();
        t_ctrl();
        t_data_fwd();
        done = 1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (5000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule